// File: doc/BRIEF.md
# Programmable Pin Deglitch Filter

This block sits behind the synchronizer of one input line. It holds a clean copy of the line, the filtered level, and replaces that copy only after the raw level has differed from it for a programmed number of clock cycles. The downstream readback and interrupt logic uses only the filtered level, so pulses shorter than the window never reach it.

The window is a mantissa times a power of two. A 4-bit count gives the mantissa and a 4-bit select gives the exponent. A prescaler emits a tick every 2^select clocks. A stability counter advances on each tick while the raw level disagrees with the filtered level. The counter restarts whenever the two agree again. A count of zero turns the filter into a plain one-cycle register. Software converts a time into the two fields. With the largest fields the window spans 15·2^15 clocks, which is about 1.2 ms at a 2.5 ns clock. A change to either field restarts the window and freezes the output for that cycle, so a reprogrammed line never sees a window made from two different settings.

Top module: `pin_deglitch`

## Requirements
- R1: While reset is asserted and right after it is released, `level_o` is 0.
- R2: With count N (1..15, unsigned, on `cnt_i[3:0]`) and select S (0..15, on `sel_i[3:0]`), a raw level that differs from `level_o` and stays the same for N·2^S consecutive rising edges appears on `level_o` on the last of those edges.
- R3: A differing raw level that returns before N·2^S edges leaves `level_o` unchanged. Two such short pulses separated by one agreeing cycle do not add up.
- R4: With count 0, `level_o` takes the raw level one clock later.
- R5: On an edge where `cnt_i` or `sel_i` differs from its value at the previous edge, the window restarts. A pending level then needs the full window of the new fields, counted from the next edge.
- R6: On that field-change edge, `level_o` keeps its value, even when the new count is 0 or the old window would have completed.
- R7: After reset the active fields are count 9 and select 4, giving a window of 144 clocks, with no field change needed.
- R8: Rising and falling raw changes are filtered by the same window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 1 | Synchronized raw line level |
| cnt_i | input | 4 | Window mantissa; 0 bypasses the filter |
| sel_i | input | 4 | Window exponent; prescale is 2^sel |
| level_o | output | 1 | Filtered line level |

## Verification
A field change and the completion of a window can land on the same edge. A field change and a bypass update can also land on the same edge. In each collision the field change must win, and `level_o` must hold. The bench provokes the first case by raising the select exactly on the edge where a two-clock window would have expired. It provokes the second by entering bypass in the same cycle that the raw level flips. It checks that the output is unchanged on that edge. It then checks that the new window runs in full from the following edge.

// File: rtl/dgl_pkg.sv
package dgl_pkg;
    localparam int CNT_W     = 4;
    localparam int SEL_W     = 4;
    localparam int DEF_CNT   = 9;
    localparam int DEF_SEL   = 4;
    localparam bit RST_LEVEL = 1'b0;
endpackage

// File: rtl/dgl_cfg_watch.sv
module dgl_cfg_watch #(
    parameter int CNT_W   = dgl_pkg::CNT_W,
    parameter int SEL_W   = dgl_pkg::SEL_W,
    parameter int DEF_CNT = dgl_pkg::DEF_CNT,
    parameter int DEF_SEL = dgl_pkg::DEF_SEL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             chg_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d.cnt = cnt_i;
        cfg_d.sel = sel_i;
        chg_o     = (cnt_i != cfg_q.cnt) || (sel_i != cfg_q.sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.cnt <= CNT_W'(DEF_CNT);
            cfg_q.sel <= SEL_W'(DEF_SEL);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cnt_o = cfg_q.cnt;
    assign sel_o = cfg_q.sel;
endmodule

// File: rtl/dgl_prescaler.sv
module dgl_prescaler #(
    parameter int SEL_W = dgl_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;

    always_comb begin
        span   = ({{PRE_W{1'b0}}, 1'b1} << sel_i) - 1'b1;
        mask   = span[PRE_W-1:0];
        tick_o = ((pre_q.pre & mask) == mask);
        pre_d.pre = clr_i ? '0 : pre_q.pre + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q.pre <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R5: a cleared prescaler cannot tick at once unless the prescale is 1
    p_quiet_after_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_i) && sel_i != '0) |-> !tick_o);
endmodule

// File: rtl/dgl_stab.sv
module dgl_stab #(
    parameter int CNT_W     = dgl_pkg::CNT_W,
    parameter bit RST_LEVEL = dgl_pkg::RST_LEVEL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             hold_i,
    input  logic             tick_i,
    output logic             level_o,
    output logic             pend_o,
    output logic             upd_o
);
    typedef struct packed {
        logic [CNT_W-1:0] stab;
        logic             level;
    } stab_t;

    stab_t st_d, st_q;
    logic  last_step;

    always_comb begin
        st_d      = st_q;
        pend_o    = (pin_i != st_q.level);
        last_step = (st_q.stab == CNT_W'(cnt_i - 1'b1));
        if (hold_i) begin
            st_d.stab = '0;
        end else if (cnt_i == '0) begin
            st_d.stab  = '0;
            st_d.level = pin_i;
        end else if (!pend_o) begin
            st_d.stab = '0;
        end else if (tick_i) begin
            if (last_step) begin
                st_d.stab  = '0;
                st_d.level = pin_i;
            end else begin
                st_d.stab = st_q.stab + 1'b1;
            end
        end
        upd_o = (st_d.level != st_q.level);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stab  <= '0;
            st_q.level <= RST_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

    // R6: the field-change edge leaves the level alone
    p_hold_keeps_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(level_o));
    // R4: bypass registers the raw level
    p_bypass_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && cnt_i == '0) |=> (level_o == $past(pin_i)));
    // R2: the stability count never reaches the programmed count
    p_stab_below_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0) |-> (st_q.stab < cnt_i));
    // R3: an agreeing raw level wipes any partial count
    p_idle_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o) |=> (st_q.stab == '0));
endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
    parameter int CNT_W     = dgl_pkg::CNT_W,
    parameter int SEL_W     = dgl_pkg::SEL_W,
    parameter int DEF_CNT   = dgl_pkg::DEF_CNT,
    parameter int DEF_SEL   = dgl_pkg::DEF_SEL,
    parameter bit RST_LEVEL = dgl_pkg::RST_LEVEL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             level_o
);
    logic [CNT_W-1:0] cnt_act;
    logic [SEL_W-1:0] sel_act;
    logic             cfg_chg;
    logic             tick;
    logic             pend;
    logic             upd;
    logic             pre_clr;

    dgl_cfg_watch #(
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W),
        .DEF_CNT(DEF_CNT),
        .DEF_SEL(DEF_SEL)
    ) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt_i(cnt_i),
        .sel_i(sel_i),
        .cnt_o(cnt_act),
        .sel_o(sel_act),
        .chg_o(cfg_chg)
    );

    assign pre_clr = cfg_chg || !pend || upd;

    dgl_prescaler #(
        .SEL_W(SEL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (pre_clr),
        .sel_i (sel_act),
        .tick_o(tick)
    );

    dgl_stab #(
        .CNT_W    (CNT_W),
        .RST_LEVEL(RST_LEVEL)
    ) u_stab (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cnt_i  (cnt_act),
        .hold_i (cfg_chg),
        .tick_i (tick),
        .level_o(level_o),
        .pend_o (pend),
        .upd_o  (upd)
    );

    // R3: when the raw level agrees, the output stays put
    p_match_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_i == level_o) |=> $stable(level_o));
    // R8: any output move, either polarity, copies the raw level
    p_flip_takes_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o != $past(level_o)) |-> (level_o == $past(pin_i)));
endmodule

// File: tb/tb_pin_deglitch.sv
module tb_pin_deglitch;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pin;
    logic [3:0] cnt;
    logic [3:0] sel;
    logic       level;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic lvl;

    pin_deglitch dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin),
        .cnt_i  (cnt),
        .sel_i  (sel),
        .level_o(level)
    );

    always #10 clk = ~clk;

    // {count[31:28], select[27:24], pulse length in clocks[23:0]}
    localparam int NV = 13;
    localparam logic [31:0] VEC [NV] = '{
        {4'd1,  4'd0,  24'd1},
        {4'd3,  4'd0,  24'd2},
        {4'd3,  4'd0,  24'd3},
        {4'd9,  4'd4,  24'd143},
        {4'd9,  4'd4,  24'd144},
        {4'd2,  4'd3,  24'd15},
        {4'd2,  4'd3,  24'd16},
        {4'd15, 4'd2,  24'd60},
        {4'd0,  4'd0,  24'd1},
        {4'd5,  4'd1,  24'd9},
        {4'd5,  4'd1,  24'd10},
        {4'd1,  4'd5,  24'd32},
        {4'd15, 4'd10, 24'd15360}
    };

    task automatic check(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: level_o=%b expected=%b at cycle %0d", req, got, exp, cycles);
        end
    endtask

    task automatic settle(input logic [3:0] c, input logic [3:0] s);
        @(negedge clk);
        cnt = c;
        sel = s;
        pin = lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: level_o=%b expected=done", level);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pin   = 1'b0;
        cnt   = 4'd9;
        sel   = 4'd4;
        lvl   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(level, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(level, 1'b0, "R1 after reset");

        // R7: default window of 144 clocks
        pin = 1'b1;
        repeat (143) @(posedge clk);
        @(negedge clk);
        check(level, 1'b0, "R7 default one short");
        @(posedge clk);
        @(negedge clk);
        check(level, 1'b1, "R7 default full");
        lvl = 1'b1;

        // table walk: R2 full windows, R3 short pulses, R4 bypass, R8 both polarities
        for (int i = 0; i < NV; i++) begin
            logic [3:0] vc;
            logic [3:0] vs;
            int         len;
            int         win;
            logic       exp;
            vc  = VEC[i][31:28];
            vs  = VEC[i][27:24];
            len = int'(VEC[i][23:0]);
            win = (vc == 4'd0) ? 1 : (int'(vc) << vs);
            settle(vc, vs);
            pin = ~lvl;
            repeat (len) @(posedge clk);
            @(negedge clk);
            exp = (len >= win) ? ~lvl : lvl;
            if (vc == 4'd0)
                check(level, exp, "R4 table bypass");
            else if (len >= win)
                check(level, exp, (lvl ? "R8 table falling R2" : "R2 table rising"));
            else
                check(level, exp, "R3 table short pulse");
            lvl = exp;
            pin = lvl;
        end

        // R3: two short pulses with one agreeing cycle between do not add
        settle(4'd3, 4'd1);
        pin = ~lvl;
        repeat (5) @(posedge clk);
        @(negedge clk);
        pin = lvl;
        @(posedge clk);
        @(negedge clk);
        pin = ~lvl;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(level, lvl, "R3 no accumulation");
        pin = lvl;

        // R5: select change mid-window restarts with the new window
        settle(4'd4, 4'd2);
        pin = ~lvl;
        repeat (10) @(posedge clk);
        @(negedge clk);
        sel = 4'd1;
        @(posedge clk);
        repeat (7) @(posedge clk);
        @(negedge clk);
        check(level, lvl, "R5 restarted window one short");
        @(posedge clk);
        @(negedge clk);
        check(level, ~lvl, "R5 restarted window full");
        lvl = ~lvl;

        // R6 and R5: field change on the edge where the old window ends
        settle(4'd2, 4'd0);
        pin = ~lvl;
        @(posedge clk);
        @(negedge clk);
        sel = 4'd1;
        @(posedge clk);
        @(negedge clk);
        check(level, lvl, "R6 hold beats window end");
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(level, lvl, "R5 new window one short");
        @(posedge clk);
        @(negedge clk);
        check(level, ~lvl, "R5 new window full");
        lvl = ~lvl;

        // R6 and R4: entering bypass on the same edge the raw level flips
        settle(4'd4, 4'd1);
        cnt = 4'd0;
        pin = ~lvl;
        @(posedge clk);
        @(negedge clk);
        check(level, lvl, "R6 hold beats bypass");
        @(posedge clk);
        @(negedge clk);
        check(level, ~lvl, "R4 bypass after hold");
        lvl = ~lvl;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule